// File: doc/BRIEF.md
# Idle-Time ECC Memory Scrubber

This block walks a programmable window of an ECC-protected memory in the background. It reads each word through the same request port that the main bus master uses. Software sets a window base, an inclusive window limit and a segment length, then pulses start. The engine reads that many consecutive words, pulses a done flag and stops. The next start continues from the word after the last one visited. When the walk passes the limit it wraps back to the base.

The memory returns corrected data together with two error flags. When a read reports a corrected single-bit error, the engine writes the corrected word back to the same address before it moves on. This keeps a second upset from turning the word into an uncorrectable one. An uncorrectable double-bit error is only counted, because the true value is unknown. Two saturating counters, one per error kind, can be cleared with a one-cycle pulse.

The main master always wins the port. The scrubber places a read or write only in a cycle when the master is not requesting. If the master is busy, the pending access waits at the same address. The memory answers a read exactly one cycle after it accepts the request.

Top module: `ecc_idle_scrubber`

## Requirements
- R1: After reset the block is idle: `busy` and `seg_done` are low, both counters are zero, and `mem_req` follows only `m_req`.
- R2: In any cycle with `m_req` high, the memory port carries the master's request unchanged (`mem_req`=1, `mem_addr`=`m_addr`, `mem_we`=`m_we`, `mem_wdata`=`m_wdata`). The scrubber issues nothing in that cycle.
- R3: A start pulse in idle reads `seg_len` words, with a value of 0 treated as 1. Then `seg_done` is high for exactly one cycle, and the block returns to idle with `busy` low.
- R4: Reads within a segment go to consecutive addresses, and an address equal to `win_limit` is followed by `win_base`. A segment begins at the word after the previous segment's last word. The first segment after reset, or any segment whose saved address lies outside [`win_base`, `win_limit`], begins at `win_base`.
- R5: A read answered with `mem_err_single`=1 and `mem_err_double`=0 is followed by exactly one write of the returned `mem_rdata` to the same address. That write is issued before the next read.
- R6: A read answered with `mem_err_double`=1, whatever the value of `mem_err_single`, causes no write. It increments the uncorrectable counter.
- R7: `corr_cnt` counts single-bit events and `uncorr_cnt` counts double-bit events. Each counter stops at 2^CNT_W-1.
- R8: A `clr_cnt` pulse sets both counters to zero on the next cycle, and it takes precedence over an increment in the same cycle.
- R9: While `m_req` is high, a pending scrub access stays at the same address. It is issued once the master goes idle, so no word is skipped or repeated.
- R10: The read result is taken from `mem_rvalid` one cycle after the read is issued. A segment of n words with s single-bit events and an idle master therefore raises `seg_done` 2n+1+s cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one segment (honoured only when idle) |
| seg_len | input | AW | Words per segment, 0 means 1 |
| win_base | input | AW | First word address of the window |
| win_limit | input | AW | Last word address of the window (inclusive) |
| clr_cnt | input | 1 | Clear both error counters |
| seg_done | output | 1 | One-cycle pulse at the end of a segment |
| busy | output | 1 | Segment in progress |
| corr_cnt | output | CNT_W | Saturating count of corrected errors |
| uncorr_cnt | output | CNT_W | Saturating count of uncorrectable errors |
| m_req | input | 1 | Main master request |
| m_we | input | 1 | Main master write enable |
| m_addr | input | AW | Main master word address |
| m_wdata | input | DW | Main master write data |
| mem_req | output | 1 | Request to the ECC memory controller |
| mem_we | output | 1 | Write enable to the memory |
| mem_addr | output | AW | Word address to the memory |
| mem_wdata | output | DW | Write data to the memory |
| mem_rvalid | input | 1 | Read data valid, one cycle after a read |
| mem_rdata | input | DW | Corrected read data |
| mem_err_single | input | 1 | Read saw a corrected single-bit error |
| mem_err_double | input | 1 | Read saw an uncorrectable error |

## Verification
Embedded assertions check these behaviours on every cycle:
- a pending access holds its address while the master owns the port;
- a corrected response always leads into the write-back state, and an uncorrectable one never does;
- the done pulse lasts one cycle;
- the counters clear and saturate correctly;
- the walk pointer stays inside the window.

Other properties are visible only across a whole segment, so only the bench's scenarios can show them:
- the exact address sequence, including wrap and resume across starts and window changes;
- that exactly the single-error words are rewritten, with the right data;
- the end-to-end segment latency.

The bench sweeps several windows and segment lengths, with and without master traffic, and uses a narrow counter so that saturation is reached.

// File: rtl/ecc_idle_scrubber.sv
module ecc_idle_scrubber #(
  parameter int AW    = 16,
  parameter int DW    = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    seg_len,
  input  logic [AW-1:0]    win_base,
  input  logic [AW-1:0]    win_limit,
  input  logic             clr_cnt,
  output logic             seg_done,
  output logic             busy,
  output logic [CNT_W-1:0] corr_cnt,
  output logic [CNT_W-1:0] uncorr_cnt,
  input  logic             m_req,
  input  logic             m_we,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_err_single,
  input  logic             mem_err_double
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WB, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] ptr, seg_cnt, seg_last;
  logic          ptr_ok;
  logic [DW-1:0] fix_data;

  wire scrub_rd = (st == S_READ) && !m_req;
  wire scrub_wr = (st == S_WB)   && !m_req;
  wire resp     = (st == S_WAIT) && mem_rvalid;
  wire hit_dbl  = resp && mem_err_double;
  wire hit_sgl  = resp && mem_err_single && !mem_err_double;
  wire step     = (resp && !hit_sgl) || scrub_wr;
  wire last     = (seg_cnt == seg_last);
  wire ptr_out  = !ptr_ok || (ptr < win_base) || (ptr > win_limit);
  wire [AW-1:0] ptr_nxt = (ptr == win_limit) ? win_base : ptr + 1'b1;

  assign mem_req   = m_req | scrub_rd | scrub_wr;
  assign mem_we    = m_req ? m_we    : scrub_wr;
  assign mem_addr  = m_req ? m_addr  : ptr;
  assign mem_wdata = m_req ? m_wdata : fix_data;
  assign seg_done  = (st == S_DONE);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      ptr_ok   <= 1'b0;
      seg_cnt  <= '0;
      seg_last <= '0;
      fix_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_READ;
          seg_cnt  <= '0;
          seg_last <= (seg_len == '0) ? '0 : seg_len - 1'b1;
          ptr_ok   <= 1'b1;
          if (ptr_out) ptr <= win_base;
        end
        S_READ: if (scrub_rd) st <= S_WAIT;
        S_WAIT: if (hit_sgl) begin
          fix_data <= mem_rdata;
          st       <= S_WB;
        end
        S_DONE: st <= S_IDLE;
        default: ;
      endcase
      if (step) begin
        ptr <= ptr_nxt;
        if (last) st <= S_DONE;
        else begin
          seg_cnt <= seg_cnt + 1'b1;
          st      <= S_READ;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_cnt   <= '0;
      uncorr_cnt <= '0;
    end else if (clr_cnt) begin
      corr_cnt   <= '0;
      uncorr_cnt <= '0;
    end else begin
      if (hit_sgl && corr_cnt != CMAX)   corr_cnt   <= corr_cnt + 1'b1;
      if (hit_dbl && uncorr_cnt != CMAX) uncorr_cnt <= uncorr_cnt + 1'b1;
    end
  end

  a_r9_hold_while_master: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_READ || st == S_WB) && m_req) |=> ((st == $past(st)) && $stable(ptr)));

  a_r10_wait_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_rd |=> (st == S_WAIT) && $stable(ptr));

  a_r5_single_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sgl |=> (st == S_WB) && $stable(ptr));

  a_r6_double_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dbl |=> (st != S_WB));

  a_r3_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> (!seg_done && !busy));

  a_r7_corr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_cnt == CMAX && !clr_cnt) |=> (corr_cnt == CMAX));

  a_r7_uncorr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_cnt == CMAX && !clr_cnt) |=> (uncorr_cnt == CMAX));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (corr_cnt == '0 && uncorr_cnt == '0));

  a_r4_ptr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && win_base <= win_limit) |-> (ptr >= win_base && ptr <= win_limit));

endmodule

// File: tb/ecc_idle_scrubber_tb.sv
module ecc_idle_scrubber_tb_top;
  localparam int AW = 4, DW = 16, CW = 3, N = 16, CMAX = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, clr_cnt, m_req, m_we;
  logic [AW-1:0] seg_len, win_base, win_limit, m_addr;
  logic [DW-1:0] m_wdata, mem_rdata;
  logic mem_rvalid, mem_err_single, mem_err_double;
  logic seg_done, busy, mem_req, mem_we;
  logic [CW-1:0] corr_cnt, uncorr_cnt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  ecc_idle_scrubber #(.AW(AW), .DW(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_len(seg_len),
    .win_base(win_base), .win_limit(win_limit), .clr_cnt(clr_cnt),
    .seg_done(seg_done), .busy(busy), .corr_cnt(corr_cnt), .uncorr_cnt(uncorr_cnt),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_err_single(mem_err_single), .mem_err_double(mem_err_double));

  int nchk = 0, nfail = 0;
  logic [DW-1:0] mem_v [N];
  int errk [N];
  int rd_log [64];
  int nrd, nwr, tk, t_done;
  bit pend, pend_scrub, mbusy, st_req, clr_req, seen_done;
  int pend_a;
  int ptr_m; bit ptr_v;
  int ec, eu;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    if (pend) begin
      mem_rvalid     = 1'b1;
      mem_rdata      = mem_v[pend_a];
      mem_err_single = pend_scrub && (errk[pend_a] == 1 || errk[pend_a] == 3);
      mem_err_double = pend_scrub && (errk[pend_a] >= 2);
    end else begin
      mem_rvalid = 1'b0; mem_err_single = 1'b0; mem_err_double = 1'b0;
    end
    pend    = 1'b0;
    start   = st_req;  st_req  = 1'b0;
    clr_cnt = clr_req; clr_req = 1'b0;
    m_req   = mbusy && ((tk * 3) % 7 < 3);
    m_addr  = AW'(tk % N);
    m_wdata = DW'(tk * 11);
    m_we    = 1'b0;
    #5;
    if (m_req) begin
      // R2: master owns the port unchanged
      chk(mem_req && mem_addr == m_addr && !mem_we && mem_wdata == m_wdata,
          "R2 master passthrough", int'(mem_addr), int'(m_addr));
      pend = 1'b1; pend_scrub = 1'b0; pend_a = int'(m_addr);
    end else if (mem_req) begin
      if (mem_we) begin
        // R5: write-back of corrected data to the last read address; R6: never on double
        chk(nrd > 0 && int'(mem_addr) == rd_log[nrd-1], "R5 writeback address",
            int'(mem_addr), nrd > 0 ? rd_log[nrd-1] : -1);
        chk(errk[mem_addr] == 1, "R6 writeback only on single", errk[mem_addr], 1);
        chk(mem_wdata == mem_v[mem_addr], "R5 writeback data",
            int'(mem_wdata), int'(mem_v[mem_addr]));
        errk[mem_addr] = 0;
        nwr++;
      end else begin
        if (nrd < 64) rd_log[nrd] = int'(mem_addr);
        nrd++;
        pend = 1'b1; pend_scrub = 1'b1; pend_a = int'(mem_addr);
      end
    end
    if (seg_done && !seen_done) begin seen_done = 1'b1; t_done = tk; end
    tk++;
  endtask

  task automatic run_seg(input int L);
    int n, ns, nd, b, lm, t0;
    int exp_a [64];
    int ek [N];
    b = int'(win_base); lm = int'(win_limit);
    for (int a = 0; a < N; a++) ek[a] = errk[a];
    if (!ptr_v || ptr_m < b || ptr_m > lm) ptr_m = b;
    ptr_v = 1'b1;
    n = (L == 0) ? 1 : L;
    ns = 0; nd = 0;
    for (int i = 0; i < n; i++) begin
      exp_a[i] = ptr_m;
      if (ek[ptr_m] == 1) begin ns++; ek[ptr_m] = 0; end
      else if (ek[ptr_m] >= 2) nd++;
      ptr_m = (ptr_m == lm) ? b : ptr_m + 1;
    end
    seg_len = AW'(L);
    nrd = 0; nwr = 0; seen_done = 1'b0;
    st_req = 1'b1;
    t0 = tk;
    tick();
    for (int k = 0; k < 400 && !seen_done; k++) tick();
    chk(seen_done, "R3 segment completes", seen_done, 1);
    chk(nrd == n, "R3 read count", nrd, n);
    for (int i = 0; i < n && i < nrd; i++)
      chk(rd_log[i] == exp_a[i], "R4 address sequence", rd_log[i], exp_a[i]);
    chk(nwr == ns, "R5 writeback count", nwr, ns);
    ec = (ec + ns > CMAX) ? CMAX : ec + ns;
    eu = (eu + nd > CMAX) ? CMAX : eu + nd;
    chk(int'(corr_cnt) == ec, "R7 corrected count", int'(corr_cnt), ec);
    chk(int'(uncorr_cnt) == eu, "R6 uncorrectable count", int'(uncorr_cnt), eu);
    if (!mbusy) chk(t_done - t0 == 2*n + 1 + ns, "R10 segment latency", t_done - t0, 2*n + 1 + ns);
    else chk(t_done - t0 >= 2*n + 1 + ns, "R9 paused segment latency", t_done - t0, 2*n + 1 + ns);
    tick();
    chk(!busy && !seg_done, "R3 back to idle", {busy, seg_done}, 0);
  endtask

  initial begin
    #3000000;
    nfail++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int bases [5] = '{0, 3, 5, 12, 0};
    int lims  [5] = '{15, 9, 5, 14, 15};
    int lens  [5] = '{3, 4, 0, 2, 15};
    rst_n = 1'b0; start = 1'b0; clr_cnt = 1'b0; m_req = 1'b0; m_we = 1'b0;
    m_addr = '0; m_wdata = '0; seg_len = '0; win_base = '0; win_limit = '0;
    mem_rvalid = 1'b0; mem_rdata = '0; mem_err_single = 1'b0; mem_err_double = 1'b0;
    pend = 1'b0; pend_scrub = 1'b0; mbusy = 1'b0; st_req = 1'b0; clr_req = 1'b0;
    tk = 0; nrd = 0; nwr = 0; ptr_v = 1'b0; ptr_m = 0; ec = 0; eu = 0; t_done = 0;
    for (int a = 0; a < N; a++) begin mem_v[a] = '0; errk[a] = 0; end
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!busy && !seg_done && !mem_req, "R1 idle after reset", {busy, seg_done, mem_req}, 0);
    chk(corr_cnt == '0 && uncorr_cnt == '0, "R1 counters zero", int'(corr_cnt) + int'(uncorr_cnt), 0);
    for (int c = 0; c < 5; c++) begin
      win_base = AW'(bases[c]); win_limit = AW'(lims[c]);
      mbusy = (c % 2) == 1;
      for (int a = 0; a < N; a++) begin
        mem_v[a] = DW'(a * 613 + c * 97);
        errk[a]  = ((a + c) % 5 == 1) ? 1 : ((a + 2*c) % 7 == 3) ? 2 : ((a + c) % 9 == 6) ? 3 : 0;
      end
      for (int s = 0; s < 4; s++) run_seg(lens[c]);
      if (c == 2) begin
        clr_req = 1'b1;
        tick();
        tick();
        // R8 clear pulse
        chk(corr_cnt == '0 && uncorr_cnt == '0, "R8 counters cleared",
            int'(corr_cnt) + int'(uncorr_cnt), 0);
        ec = 0; eu = 0;
      end
    end
    // R7 saturation reached over the sweep
    chk(ec == CMAX || eu == CMAX, "R7 saturation reached", ec, CMAX);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule